// File: doc/BRIEF.md
# Host Memory Access Port

This block lets an external host reach the on-chip program and data memories over a 16-bit bus that carries both addresses and data. The host strobes arrive with no relation to the core clock. Each one passes through a synchronizer, and the block then turns it into a single-cycle request on the matching memory port. A latch cycle does one of two things, chosen by the top bus bit. It either sets a start address together with a memory-type bit, or it loads an 8-bit overlay value.

After a start address is set, each host read or write strobe moves one transfer. The internal address then steps by itself, so a block of consecutive words needs only one address. Data words are 16 bits and take one transfer each. Program words are 24 bits and take two transfers: the upper 16 bits first, then the low byte. The address steps only after the second half. Writes into the control-register window at the top of data memory are blocked. The acknowledge line goes low while an access is in flight and returns high when the host may start the next one.

Top module: `host_mem_port`

## Requirements
- R1: After reset, h_ack is 1, h_ad_out is 0, ovl_sel is 0 and no memory request is issued.
- R2: A falling edge of h_latch while h_sel is active, with bus bit 15 = 0, loads bits 13:0 as the start address and bit 14 as the memory type (0 = program memory, 1 = data memory). It also restarts the program-word half sequence at the upper half.
- R3: A latch with bit 15 = 1 and bits 14:8 all zero loads bits 7:0 into ovl_sel and leaves the address unchanged. If any of bits 14:8 is set, the latch changes nothing.
- R4: A read or write strobe rising at the ports is detected after two clock edges. The memory request is issued for one cycle after the third edge, and h_ack is low from that third edge through the fifth. At the fifth edge h_ack is back at 1 and read data is on h_ad_out.
- R5: A data-memory transfer moves one 16-bit word through a single dm_req cycle. The port never requests both memories in the same cycle.
- R6: A program-memory write takes two transfers. Only the second transfer issues a write, and the word written is {first transfer bits 15:0, second transfer bits 7:0}.
- R7: A program-memory read issues one memory read on the first transfer and returns word bits 23:8. The second transfer returns {8'h00, word bits 7:0} without a memory access.
- R8: The address steps by one after every data-memory transfer and after the second half of every program-memory word. It wraps from 14'h3FFF to 14'h0000.
- R9: Data-memory writes to addresses at or above CTRL_BASE (default 14'h3FE0) issue no request, but the address still steps. Reads in that range are allowed.
- R10: A strobe or latch is ignored when h_sel is inactive in both the current and the previous synchronized sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| h_sel | input | 1 | Host select, active high, asynchronous |
| h_latch | input | 1 | Host address-latch strobe, captured on its falling edge |
| h_rd | input | 1 | Host read strobe, active high |
| h_wr | input | 1 | Host write strobe, active high |
| h_ad_in | input | 16 | Host address/data bus into the port |
| h_ad_out | output | 16 | Read data returned to the host |
| h_ack | output | 1 | 1 = port idle and previous access finished |
| ovl_sel | output | 8 | Overlay value loaded by a latch cycle |
| pm_req | output | 1 | Program-memory request, one cycle |
| pm_we | output | 1 | Program-memory write enable |
| pm_addr | output | 14 | Program-memory address |
| pm_wdata | output | 24 | Program-memory write word |
| pm_rdata | input | 24 | Program-memory read word, valid one cycle after the request |
| dm_req | output | 1 | Data-memory request, one cycle |
| dm_we | output | 1 | Data-memory write enable |
| dm_addr | output | 14 | Data-memory address |
| dm_wdata | output | 16 | Data-memory write word |
| dm_rdata | input | 16 | Data-memory read word, valid one cycle after the request |

## Verification
Every strobe is driven on a falling clock edge. The bench then counts rising edges from that point. It expects h_ack still high after the second edge, low after the third, and high again after the fifth, where the read word is sampled. A latch takes effect three edges after its falling strobe, and the bench waits four edges before the next stimulus. Memory contents and request counts are checked only after h_ack has returned, so every result is read one full cycle after the edge that produced it.

// File: rtl/hmp_pkg.sv
package hmp_pkg;

  typedef enum logic {
    MT_PM = 1'b0,
    MT_DM = 1'b1
  } mem_type_e;

  typedef enum logic [1:0] {
    XK_DM    = 2'd0,
    XK_PM_HI = 2'd1,
    XK_PM_LO = 2'd2
  } xfer_kind_e;

  typedef struct packed {
    logic latch_fall;
    logic rd_rise;
    logic wr_rise;
  } host_evt_t;

endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] prev_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              last_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain  <= '0;
        last_q <= 1'b0;
      end else begin
        chain  <= {chain[STAGES-2:0], async_i[g]};
        last_q <= chain[STAGES-1];
      end
    end

    assign level_o[g] = chain[STAGES-1];
    assign prev_o[g]  = last_q;
  end

endmodule

// File: rtl/hmp_addr_ctl.sv
module hmp_addr_ctl
  import hmp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 14,
  parameter int OVL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_ev,
  input  logic              step,
  input  logic [DATA_W-1:0] bus,
  output logic [ADDR_W-1:0] addr_o,
  output mem_type_e         mtype_o,
  output logic              pm_lo_o,
  output logic [OVL_W-1:0]  ovl_o
);

  localparam int FLAG_BIT = DATA_W - 1;
  localparam int TYPE_BIT = ADDR_W;

  logic ovl_ok;
  assign ovl_ok = bus[FLAG_BIT] && (bus[FLAG_BIT-1:OVL_W] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      mtype_o <= MT_PM;
      pm_lo_o <= 1'b0;
      ovl_o   <= '0;
    end else if (latch_ev) begin
      if (!bus[FLAG_BIT]) begin
        addr_o  <= bus[ADDR_W-1:0];
        mtype_o <= mem_type_e'(bus[TYPE_BIT]);
        pm_lo_o <= 1'b0;
      end else if (ovl_ok) begin
        ovl_o <= bus[OVL_W-1:0];
      end
    end else if (step) begin
      if (mtype_o == MT_DM) begin
        addr_o <= addr_o + 1'b1;
      end else begin
        if (pm_lo_o) addr_o <= addr_o + 1'b1;
        pm_lo_o <= ~pm_lo_o;
      end
    end
  end

endmodule

// File: rtl/hmp_xfer.sv
module hmp_xfer
  import hmp_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          PM_W      = 24,
  parameter int          ADDR_W    = 14,
  parameter int unsigned CTRL_BASE = 'h3FE0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_ev,
  input  logic              wr_ev,
  input  logic [ADDR_W-1:0] addr,
  input  mem_type_e         mtype,
  input  logic              pm_lo,
  input  logic [DATA_W-1:0] bus,
  input  logic [PM_W-1:0]   pm_rdata,
  input  logic [DATA_W-1:0] dm_rdata,
  output logic              step_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              pm_req_o,
  output logic              pm_we_o,
  output logic [ADDR_W-1:0] pm_addr_o,
  output logic [PM_W-1:0]   pm_wdata_o,
  output logic              dm_req_o,
  output logic              dm_we_o,
  output logic [ADDR_W-1:0] dm_addr_o,
  output logic [DATA_W-1:0] dm_wdata_o
);

  localparam int LO_W = PM_W - DATA_W;
  localparam logic [ADDR_W-1:0] CTRL_LIM = ADDR_W'(CTRL_BASE);

  xfer_kind_e        kind_now, kind_q;
  logic              is_wr, rd_q, stage1, stage2, ctrl_hit;
  logic [DATA_W-1:0] whold;
  logic [LO_W-1:0]   rhold;

  assign step_o   = ack_o && (rd_ev || wr_ev);
  assign is_wr    = wr_ev;
  assign ctrl_hit = (addr >= CTRL_LIM);

  always_comb begin
    if (mtype == MT_DM)  kind_now = XK_DM;
    else if (pm_lo)      kind_now = XK_PM_LO;
    else                 kind_now = XK_PM_HI;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o      <= 1'b1;
      dout_o     <= '0;
      pm_req_o   <= 1'b0;
      pm_we_o    <= 1'b0;
      pm_addr_o  <= '0;
      pm_wdata_o <= '0;
      dm_req_o   <= 1'b0;
      dm_we_o    <= 1'b0;
      dm_addr_o  <= '0;
      dm_wdata_o <= '0;
      stage1     <= 1'b0;
      stage2     <= 1'b0;
      rd_q       <= 1'b0;
      kind_q     <= XK_DM;
      whold      <= '0;
      rhold      <= '0;
    end else begin
      pm_req_o <= 1'b0;
      pm_we_o  <= 1'b0;
      dm_req_o <= 1'b0;
      dm_we_o  <= 1'b0;
      stage1   <= step_o;
      stage2   <= stage1;

      if (step_o) begin
        ack_o  <= 1'b0;
        kind_q <= kind_now;
        rd_q   <= !is_wr;
        case (kind_now)
          XK_DM: begin
            if (!is_wr || !ctrl_hit) begin
              dm_req_o   <= 1'b1;
              dm_we_o    <= is_wr;
              dm_addr_o  <= addr;
              dm_wdata_o <= bus;
            end
          end
          XK_PM_HI: begin
            if (is_wr) begin
              whold <= bus;
            end else begin
              pm_req_o  <= 1'b1;
              pm_addr_o <= addr;
            end
          end
          default: begin
            if (is_wr) begin
              pm_req_o   <= 1'b1;
              pm_we_o    <= 1'b1;
              pm_addr_o  <= addr;
              pm_wdata_o <= {whold, bus[LO_W-1:0]};
            end
          end
        endcase
      end

      if (stage2) begin
        ack_o <= 1'b1;
        if (rd_q) begin
          case (kind_q)
            XK_DM:    dout_o <= dm_rdata;
            XK_PM_HI: begin
              dout_o <= pm_rdata[PM_W-1:LO_W];
              rhold  <= pm_rdata[LO_W-1:0];
            end
            default:  dout_o <= {{(DATA_W-LO_W){1'b0}}, rhold};
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
  import hmp_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          PM_W      = 24,
  parameter int          ADDR_W    = 14,
  parameter int          OVL_W     = 8,
  parameter int          SYNC_STG  = 2,
  parameter int unsigned CTRL_BASE = 'h3FE0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_sel,
  input  logic              h_latch,
  input  logic              h_rd,
  input  logic              h_wr,
  input  logic [DATA_W-1:0] h_ad_in,
  output logic [DATA_W-1:0] h_ad_out,
  output logic              h_ack,
  output logic [OVL_W-1:0]  ovl_sel,
  output logic              pm_req,
  output logic              pm_we,
  output logic [ADDR_W-1:0] pm_addr,
  output logic [PM_W-1:0]   pm_wdata,
  input  logic [PM_W-1:0]   pm_rdata,
  output logic              dm_req,
  output logic              dm_we,
  output logic [ADDR_W-1:0] dm_addr,
  output logic [DATA_W-1:0] dm_wdata,
  input  logic [DATA_W-1:0] dm_rdata
);

  localparam int NSTROBE = 4;

  logic [NSTROBE-1:0] lvl, prv;
  logic               sel_ok, step;
  host_evt_t          evt;
  logic [ADDR_W-1:0]  cur_addr;
  mem_type_e          cur_type;
  logic               cur_lo;

  hmp_sync #(.N(NSTROBE), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({h_wr, h_rd, h_latch, h_sel}),
    .level_o (lvl),
    .prev_o  (prv)
  );

  assign sel_ok         = lvl[0] | prv[0];
  assign evt.latch_fall = sel_ok & ~lvl[1] & prv[1];
  assign evt.rd_rise    = sel_ok &  lvl[2] & ~prv[2];
  assign evt.wr_rise    = sel_ok &  lvl[3] & ~prv[3];

  hmp_addr_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OVL_W(OVL_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .latch_ev (evt.latch_fall),
    .step     (step),
    .bus      (h_ad_in),
    .addr_o   (cur_addr),
    .mtype_o  (cur_type),
    .pm_lo_o  (cur_lo),
    .ovl_o    (ovl_sel)
  );

  hmp_xfer #(.DATA_W(DATA_W), .PM_W(PM_W), .ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE)) u_xfer (
    .clk        (clk),
    .rst        (rst),
    .rd_ev      (evt.rd_rise),
    .wr_ev      (evt.wr_rise),
    .addr       (cur_addr),
    .mtype      (cur_type),
    .pm_lo      (cur_lo),
    .bus        (h_ad_in),
    .pm_rdata   (pm_rdata),
    .dm_rdata   (dm_rdata),
    .step_o     (step),
    .ack_o      (h_ack),
    .dout_o     (h_ad_out),
    .pm_req_o   (pm_req),
    .pm_we_o    (pm_we),
    .pm_addr_o  (pm_addr),
    .pm_wdata_o (pm_wdata),
    .dm_req_o   (dm_req),
    .dm_we_o    (dm_we),
    .dm_addr_o  (dm_addr),
    .dm_wdata_o (dm_wdata)
  );

endmodule

// File: rtl/hmp_chk.sv
module hmp_chk #(
  parameter int          ADDR_W    = 14,
  parameter int unsigned CTRL_BASE = 'h3FE0
) (
  input logic              clk,
  input logic              rst,
  input logic              h_ack,
  input logic              pm_req,
  input logic              dm_req,
  input logic              dm_we,
  input logic [ADDR_W-1:0] dm_addr
);

  // R4
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (pm_req || dm_req) |-> !h_ack);

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(h_ack) |=> (!h_ack ##1 h_ack));

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (pm_req || dm_req) |=> !(pm_req || dm_req));

  // R5
  one_mem_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pm_req, dm_req}));

  // R9
  ctrl_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (dm_req && dm_we) |-> (dm_addr < ADDR_W'(CTRL_BASE)));

endmodule

bind host_mem_port hmp_chk #(.ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE)) u_hmp_chk (
  .clk     (clk),
  .rst     (rst),
  .h_ack   (h_ack),
  .pm_req  (pm_req),
  .dm_req  (dm_req),
  .dm_we   (dm_we),
  .dm_addr (dm_addr)
);

// File: tb/test_host_mem_port.sv
module test_host_mem_port;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_sel = 1'b0, h_latch = 1'b0, h_rd = 1'b0, h_wr = 1'b0;
  logic [15:0] h_ad_in = '0;
  logic [15:0] h_ad_out;
  logic        h_ack;
  logic [7:0]  ovl_sel;
  logic        pm_req, pm_we, dm_req, dm_we;
  logic [13:0] pm_addr, dm_addr;
  logic [23:0] pm_wdata, pm_rdata;
  logic [15:0] dm_wdata, dm_rdata;

  int errors = 0;
  int checks = 0;
  int pm_wr_cnt = 0, pm_rd_cnt = 0, dm_wr_cnt = 0, dm_rd_cnt = 0;

  logic [23:0] pm_mem [256];
  logic [15:0] dm_mem [256];

  always #4 clk = ~clk;

  host_mem_port i_host_mem_port (
    .clk(clk), .rst(rst), .h_sel(h_sel), .h_latch(h_latch), .h_rd(h_rd), .h_wr(h_wr),
    .h_ad_in(h_ad_in), .h_ad_out(h_ad_out), .h_ack(h_ack), .ovl_sel(ovl_sel),
    .pm_req(pm_req), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata), .pm_rdata(pm_rdata),
    .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_rdata(dm_rdata)
  );

  function automatic logic [23:0] pm_pat(input int i);
    logic [7:0] b = 8'(i);
    return {b, b ^ 8'h5A, ~b};
  endfunction

  function automatic logic [15:0] dm_pat(input int i);
    logic [7:0] b = 8'(i);
    return {b ^ 8'hC3, b};
  endfunction

  always @(posedge clk) begin
    if (pm_req) begin
      if (pm_we) begin pm_mem[pm_addr[7:0]] <= pm_wdata; pm_wr_cnt <= pm_wr_cnt + 1; end
      else begin pm_rdata <= pm_mem[pm_addr[7:0]]; pm_rd_cnt <= pm_rd_cnt + 1; end
    end
    if (dm_req) begin
      if (dm_we) begin dm_mem[dm_addr[7:0]] <= dm_wdata; dm_wr_cnt <= dm_wr_cnt + 1; end
      else begin dm_rdata <= dm_mem[dm_addr[7:0]]; dm_rd_cnt <= dm_rd_cnt + 1; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_latch(input logic [15:0] w);
    h_ad_in = w; h_latch = 1'b1;
    tick(3);
    h_latch = 1'b0;
    tick(4);
  endtask

  // one transfer with R4 timing checks; starts and ends on a falling edge
  task automatic acc(input logic w, input logic [15:0] d, output logic [15:0] q);
    h_ad_in = d;
    if (w) h_wr = 1'b1; else h_rd = 1'b1;
    tick(2); chk("R4 ack high through second edge", h_ack, 1);
    tick(1); chk("R4 ack low after third edge", h_ack, 0);
    tick(2); chk("R4 ack back after fifth edge", h_ack, 1);
    q = h_ad_out;
    h_rd = 1'b0; h_wr = 1'b0;
    tick(3);
  endtask

  initial begin
    logic [15:0] q;
    int          pw0, pr0, dw0, dr0;
    for (int i = 0; i < 256; i++) begin pm_mem[i] = pm_pat(i); dm_mem[i] = dm_pat(i); end
    pm_rdata = '0; dm_rdata = '0;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 ack", h_ack, 1);
    chk("R1 dout", h_ad_out, 0);
    chk("R1 overlay", ovl_sel, 0);
    chk("R1 no requests", pm_wr_cnt + pm_rd_cnt + dm_wr_cnt + dm_rd_cnt, 0);
    h_sel = 1'b1;
    tick(3);

    // R2 R5 R8 data reads from 0x0020
    host_latch(16'h4020);
    for (int i = 0; i < 8; i++) begin
      acc(1'b0, 16'h0, q);
      chk("R5 R8 dm read word", q, dm_pat(32 + i));
    end

    // R5 R8 data writes from 0x0040
    host_latch(16'h4040);
    for (int i = 0; i < 6; i++) acc(1'b1, 16'h1000 + 16'(i) * 16'h0111, q);
    for (int i = 0; i < 6; i++) chk("R5 R8 dm written", dm_mem[64 + i], 16'h1000 + 16'(i) * 16'h0111);

    // R6 program writes from 0x0030
    pw0 = pm_wr_cnt;
    host_latch(16'h0030);
    for (int i = 0; i < 4; i++) begin
      acc(1'b1, 16'hB000 + 16'(i), q);
      acc(1'b1, {8'hEE, 8'(i * 16 + 7)}, q);
    end
    for (int i = 0; i < 4; i++) chk("R6 pm word", pm_mem[48 + i], {16'hB000 + 16'(i), 8'(i * 16 + 7)});
    chk("R6 one write per word", pm_wr_cnt - pw0, 4);

    // R7 program reads from 0x0050
    pr0 = pm_rd_cnt;
    host_latch(16'h0050);
    for (int i = 0; i < 3; i++) begin
      acc(1'b0, 16'h0, q);
      chk("R7 pm upper part", q, pm_pat(80 + i) >> 8);
      acc(1'b0, 16'h0, q);
      chk("R7 pm low byte", q, {8'h00, pm_pat(80 + i) & 24'hFF});
    end
    chk("R7 one read per word", pm_rd_cnt - pr0, 3);

    // R2 relatch restarts the half sequence
    host_latch(16'h0050);
    acc(1'b0, 16'h0, q);
    host_latch(16'h0050);
    acc(1'b0, 16'h0, q);
    chk("R2 relatch restarts at upper half", q, pm_pat(80) >> 8);

    // R8 wrap from 0x3FFF
    host_latch(16'h3FFF);
    acc(1'b1, 16'h1234, q); acc(1'b1, 16'h0056, q);
    acc(1'b1, 16'h789A, q); acc(1'b1, 16'h00BC, q);
    chk("R8 word at 0x3FFF", pm_mem[255], 24'h123456);
    chk("R8 wrapped to 0x0000", pm_mem[0], 24'h789ABC);

    // R9 control window guard
    dw0 = dm_wr_cnt;
    host_latch(16'h7FDF);
    acc(1'b1, 16'hAAAA, q);
    acc(1'b1, 16'h5555, q);
    chk("R9 last plain word written", dm_mem[8'hDF], 16'hAAAA);
    chk("R9 control word untouched", dm_mem[8'hE0], dm_pat(8'hE0));
    chk("R9 one write request only", dm_wr_cnt - dw0, 1);
    acc(1'b0, 16'h0, q);
    chk("R9 R8 read allowed after step", q, dm_pat(8'hE1));

    // R3 overlay
    host_latch(16'h4060);
    host_latch(16'h805C);
    chk("R3 overlay loaded", ovl_sel, 8'h5C);
    acc(1'b0, 16'h0, q);
    chk("R3 address kept by overlay latch", q, dm_pat(8'h60));
    host_latch(16'h8133);
    chk("R3 bad overlay ignored", ovl_sel, 8'h5C);
    acc(1'b0, 16'h0, q);
    chk("R3 address kept by bad latch", q, dm_pat(8'h61));

    // R10 select inactive
    h_sel = 1'b0; tick(3);
    host_latch(16'h4070);
    dr0 = dm_rd_cnt;
    h_rd = 1'b1; tick(6);
    chk("R10 ack stays high", h_ack, 1);
    chk("R10 no request", dm_rd_cnt - dr0, 0);
    h_rd = 1'b0; tick(3);
    h_sel = 1'b1; tick(3);
    acc(1'b0, 16'h0, q);
    chk("R10 latch ignored, address continues", q, dm_pat(8'h62));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule